// File: doc/BRIEF.md
# Sequential Booth Multiplier (radix 2)

This block multiplies two signed two's-complement operands of `W` bits and returns a `2W`-bit signed product. It works over several cycles. A one-cycle `start` pulse captures both operands. The block then runs one recoding step per clock, for `W` clocks in total. In each step it looks at the low bit of the multiplier register and the bit most recently shifted out below it. From that pair it adds the captured multiplicand to the running accumulator, subtracts it, or leaves the accumulator as it is. It then shifts the whole accumulator/multiplier/extra-bit chain one place to the right, keeping the sign.

Because the add and subtract are formed one bit wider than the accumulator, the arithmetic shift never loses a sign. This holds even when the multiplicand is the most negative value. No sign correction is needed at the end. While the block is working, `busy` is high. A one-cycle `done` marks the cycle in which `product` first holds the result. The product then stays unchanged until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done` and `product` are all zero.
- R2: A `start` seen at a clock edge while `busy` is low is accepted: `busy` is high in the following cycle.
- R3: After an accepted start, `busy` stays high for exactly `W` cycles and then falls.
- R4: `done` is high for exactly one cycle. That cycle follows the last busy cycle, `busy` is low during it, and a start in that cycle is accepted.
- R5: In the `done` cycle, `product` equals the signed product of the captured operands as a `2W`-bit two's-complement value.
- R6: Operands equal to the most negative value (bit pattern 1 followed by zeros) in either or both positions give the exact `2W`-bit product, including +2^(2W-2).
- R7: A `start` seen while `busy` is high is ignored. Neither the operand values present then nor the pulse itself changes the timing or the result of the running operation.
- R8: Outside a running operation and with no start, `product` holds its value.
- R9: Per step, the pair (multiplier LSB, extra bit) selects the action: 10 subtracts the multiplicand, 01 adds it, 00 and 11 leave the accumulator unchanged before the shift. Multipliers made of long runs of ones, alternating bits, or zero therefore give correct products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture operands and begin an operation when idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion marker |
| product | output | 2W | Signed product, valid from `done` until the next accepted start |

## Verification
The checker takes for granted only that `start` is a synchronous level sampled at each edge. The operand buses may change at any time, even in the middle of an operation, because they are captured once on acceptance. The bench drives every input half a period away from the active edge. It deliberately changes the operand buses and pulses `start` during a busy period, so the claim that those values are ignored is put to use instead of assumed. A start placed exactly in the `done` cycle exercises back-to-back acceptance.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        OP_KEEP = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

    // Pair decode: current multiplier LSB and the bit shifted out before it
    function automatic booth_op_e booth_pick(input logic cur, input logic prev);
        booth_op_e r;
        case ({cur, prev})
            2'b10:   r = OP_SUB;
            2'b01:   r = OP_ADD;
            default: r = OP_KEEP;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur,
    input  logic      prev,
    output booth_op_e op
);
    always_comb op = booth_pick(cur, prev);
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mcand,
    input  booth_op_e    op,
    output logic [W:0]   sum
);
    localparam int XW = W + 1;

    logic [XW-1:0] a_x;
    logic [XW-1:0] b_x;

    // One guard bit keeps the result exact for every operand pair
    always_comb begin
        a_x = {acc[W-1], acc};
        b_x = {mcand[W-1], mcand};
        case (op)
            OP_ADD:  sum = a_x + b_x;
            OP_SUB:  sum = a_x + (~b_x) + XW'(1);
            default: sum = a_x;
        endcase
    end
endmodule

// File: rtl/booth_seqctl.sv
module booth_seqctl #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          load,
    output logic          step,
    output logic [CW-1:0] cnt
);
    logic last;

    assign load = start && !busy;
    assign step = busy;
    assign last = busy && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= last;
            if (load) begin
                busy <= 1'b1;
                cnt  <= CW'(W);
            end else if (step) begin
                cnt <= cnt - CW'(1);
                if (last) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  acc;
    logic [W-1:0]  mq;
    logic [W-1:0]  mcand_q;
    logic          qx;
    logic [CW-1:0] cnt;
    logic          load;
    logic          step;
    booth_op_e     op;
    logic [W:0]    sum;

    booth_seqctl #(.W(W), .CW(CW)) u_ctl (
        .clk(clk), .rst(rst), .start(start),
        .busy(busy), .done(done), .load(load), .step(step), .cnt(cnt)
    );

    booth_recode u_rec (.cur(mq[0]), .prev(qx), .op(op));

    booth_addsub #(.W(W)) u_as (.acc(acc), .mcand(mcand_q), .op(op), .sum(sum));

    // Shift chain: {sum, mq, qx} moves right one place, sum sign kept
    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            mq      <= '0;
            qx      <= 1'b0;
            mcand_q <= '0;
        end else if (load) begin
            acc     <= '0;
            mq      <= mplier;
            qx      <= 1'b0;
            mcand_q <= mcand;
        end else if (step) begin
            acc <= sum[W:1];
            mq  <= {sum[0], mq[W-1:1]};
            qx  <= mq[0];
        end
    end

    assign product = {acc, mq};
endmodule

// File: rtl/booth_seq_mult_chk.sv
module booth_seq_mult_chk #(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [CW-1:0]  cnt,
    input logic [W-1:0]   acc,
    input logic [W-1:0]   mq,
    input logic           qx,
    input logic [W-1:0]   mcand_q,
    input logic [2*W-1:0] product
);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && cnt == CW'(W)));

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt > CW'(1) && !start) |=> (busy && cnt == $past(cnt) - CW'(1)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    ignore_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(mcand_q));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(product));

    // R9
    skip_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (mq[0] == qx) && !start) |=> (acc == {$past(acc[W-1]), $past(acc[W-1:1])}));
endmodule

bind booth_seq_mult booth_seq_mult_chk #(.W(W), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .cnt(cnt), .acc(acc), .mq(mq), .qx(qx), .mcand_q(mcand_q),
    .product(product)
);

// File: tb/sim_booth_seq_mult.sv
module sim_booth_seq_mult;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic [W-1:0]   mcand;
    logic [W-1:0]   mplier;
    logic           busy;
    logic           done;
    logic [2*W-1:0] product;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    string cur_tag = "R5";

    always #4 clk = ~clk;

    booth_seq_mult #(.W(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplier(mplier),
        .busy(busy), .done(done), .product(product)
    );

    // Behavioural reference
    logic [2*W-1:0] exp_q[$];
    bit             m_busy, m_done, m_have;
    int             m_left;
    logic [2*W-1:0] m_prod;

    function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b);
        longint pa = longint'($signed(a));
        longint pb = longint'($signed(b));
        longint p  = pa * pb;
        return p[2*W-1:0];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_have = 0; m_left = 0; m_prod = '0;
            exp_q.delete();
        end else begin
            m_done = 0;
            if (!m_busy && start) begin
                exp_q.push_back(ref_mul(mcand, mplier));
                m_busy = 1; m_left = W;
            end else if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0; m_done = 1; m_have = 1;
                    m_prod = exp_q.pop_front();
                end
            end
        end
    end

    task automatic chk(bit ok, string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison, half a period after the edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(busy == m_busy, "R3", {15'd0, busy}, {15'd0, m_busy});
            chk(done == m_done, "R4", {15'd0, done}, {15'd0, m_done});
            if (m_done)
                chk(product == m_prod, cur_tag, product, m_prod);
            else if (m_have && !m_busy)
                chk(product == m_prod, "R8", product, m_prod);
        end
    end

    task automatic do_op(logic [W-1:0] a, logic [W-1:0] b, string tag);
        @(negedge clk);
        start = 1'b1; mcand = a; mplier = b; cur_tag = tag;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", {15'd0, busy}, 16'd1);
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mcand = '0; mplier = '0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && product == 0, "R1", product, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && product == 0, "R1", product, '0);

        do_op(8'hF7, 8'hF3, "R5");          // -9 * -13 = +117
        do_op(8'h00, 8'h4D, "R5");
        do_op(8'h01, 8'hFF, "R5");
        do_op(8'h80, 8'h80, "R6");          // +16384
        do_op(8'h80, 8'h7F, "R6");
        do_op(8'h7F, 8'h80, "R6");
        do_op(8'hDB, 8'h55, "R9");          // alternating multiplier bits
        do_op(8'h64, 8'hFF, "R9");          // run of ones
        do_op(8'h3C, 8'h00, "R9");          // all skips
        do_op(8'h2B, 8'h7E, "R9");

        // R7: restart attempt mid-operation with different operands
        @(negedge clk);
        start = 1'b1; mcand = 8'd25; mplier = 8'hFA; cur_tag = "R7";
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        start = 1'b1; mcand = 8'd99; mplier = 8'd99;
        @(negedge clk);
        start = 1'b0; mcand = 8'h11; mplier = 8'h22;
        while (m_busy) @(negedge clk);
        @(negedge clk);

        // R4: start placed in the done cycle is accepted
        @(negedge clk);
        start = 1'b1; mcand = 8'hC8; mplier = 8'h13; cur_tag = "R4";
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        start = 1'b1; mcand = 8'h9D; mplier = 8'hE2;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R4", {15'd0, busy}, 16'd1);
        while (m_busy) @(negedge clk);
        @(negedge clk);

        for (int i = 0; i < 300; i++)
            do_op(W'($urandom), W'($urandom), "R5");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule